// File: doc/BRIEF.md
# Single-Clock FIFO with Guarded Push and Pop

This block is a first-in first-out buffer that runs on one clock. A producer offers a word with `push` and `push_data`; a consumer takes words with `pop` and sees them on `pop_data`. The block reports its state through `full`, `empty` and a `level` count of stored words. The storage depth is a power of two, set by the address width.

Both sides follow a valid/ready style of back-pressure. `push` is the producer's valid, and `!full` is its ready. `pop` is the consumer's request, and `!empty` tells it that a word is there. A push offered while `full` is high is not taken, and a pop offered while `empty` is high is not taken, provided the matching guard parameter is on. With a guard off, offering a word into a full buffer, or popping an empty one, is illegal use and its result is not defined. The guard flags are sampled before the clock edge. So when the buffer is full, a push paired with a pop is still refused, and when it is empty, a pop paired with a push is still refused.

There are two ways to clear the buffer. `sclr` clears it at the next clock edge. `arst` clears it at once, whatever the clock is doing. A parameter can hold the internal clear on until a clock edge, so that releasing `arst` never races a push. A second parameter picks the read style. In registered style, an accepted pop places the word on `pop_data` after the edge. In look-ahead style, the oldest word is already on `pop_data`, and a pop moves on to the next one.

Top module: `sc_fifo`

## Requirements
- R1: Words leave in the order they were accepted. `level` equals the number of accepted pushes minus accepted pops since the last clear.
- R2: `empty` is 1 exactly when `level` is 0. `full` is 1 exactly when `level` equals 2^ADDR_W. The two flags are never 1 together.
- R3: With the overflow guard on, a push while `full` is 1 is discarded and the stored words stay unchanged. This holds even when `pop` is asserted in the same cycle; the pop is still taken.
- R4: With the underflow guard on, a pop while `empty` is 1 is discarded and the read position does not move. This holds even when `push` is asserted in the same cycle; the push is still taken.
- R5: A push and a pop together, with neither flag set, leave `level` unchanged and move both positions.
- R6: `sclr` high at a clock edge clears the buffer, with priority over `push` and `pop`. After that edge `empty` is 1, `full` is 0, `level` is 0, and in registered style `pop_data` is 0.
- R7: `arst` clears the buffer with no clock edge needed. A pulse shorter than one clock period leaves `empty` at 1, `full` at 0, `level` at 0 and registered-style `pop_data` at 0 before the next edge.
- R8: With SYNC_RELEASE=1, the buffer stays in reset through the second rising edge after `arst` falls, so a push at the first edge is ignored. With SYNC_RELEASE=0, a push at the first edge after the fall is accepted.
- R9: In registered style (RD_STYLE=RD_REGISTERED), an accepted pop puts the oldest word on `pop_data` after that edge. `pop_data` then holds until the next accepted pop or clear.
- R10: In look-ahead style (RD_STYLE=RD_LOOKAHEAD), `pop_data` shows the oldest stored word whenever `empty` is 0. A word pushed into an empty buffer appears on `pop_data` right after the edge that takes it, and `empty` falls at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| arst | input | 1 | Asynchronous clear, active high |
| sclr | input | 1 | Synchronous clear, active high |
| push | input | 1 | Producer offers `push_data` this cycle |
| push_data | input | DATA_W | Word to store |
| full | output | 1 | Buffer holds 2^ADDR_W words; not ready for a push |
| pop | input | 1 | Consumer takes a word this cycle |
| pop_data | output | DATA_W | Output word (registered or look-ahead, per RD_STYLE) |
| empty | output | 1 | No word stored |
| level | output | ADDR_W+1 | Number of stored words |

## Verification
Two copies of the block, one in each read style and one with each reset-release setting, get the same stimulus and are compared against one queue model. Random phases bias the traffic toward filling, toward draining and toward balance. Filling shows whether the full flag and the overflow guard are right. Draining does the same for the empty flag and the underflow guard. Balanced traffic tests the wrapping of positions and the ordering under simultaneous push and pop. Directed cases cover pushing into a full buffer with and without a pop, and popping an empty one with and without a push. They also cover a sub-cycle `arst` pulse, which shows the clear is truly asynchronous, and a push at the first edge after release, which is where the synchronized and the direct release differ.

// File: rtl/sc_fifo_pkg.sv
package sc_fifo_pkg;

  // How the output word is presented to the consumer
  typedef enum logic {
    RD_REGISTERED = 1'b0,  // word appears after the accepted pop
    RD_LOOKAHEAD  = 1'b1   // head word visible before the pop
  } rd_style_e;

endpackage

// File: rtl/sc_fifo_rst.sv
module sc_fifo_rst #(
  parameter bit SYNC_RELEASE = 1'b1
) (
  input  logic clk,
  input  logic arst,
  output logic rst_o
);

  generate
    if (SYNC_RELEASE) begin : g_sync
      logic [1:0] hold_q;
      // assertion is immediate through the async set; release walks two stages
      always_ff @(posedge clk or posedge arst) begin
        if (arst) hold_q <= 2'b11;
        else      hold_q <= {hold_q[0], 1'b0};
      end
      assign rst_o = arst | hold_q[1];
    end else begin : g_direct
      logic unused_clk;
      assign unused_clk = clk;
      assign rst_o      = arst;
    end
  endgenerate

endmodule

// File: rtl/sc_fifo_ptr.sv
module sc_fifo_ptr #(
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)      ptr <= '0;
    else if (clr) ptr <= '0;
    else if (adv) ptr <= ptr + PW'(1);
  end

endmodule

// File: rtl/sc_fifo_store.sv
module sc_fifo_store
  import sc_fifo_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter rd_style_e   RD_STYLE = RD_REGISTERED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  generate
    if (RD_STYLE == RD_REGISTERED) begin : g_reg
      always_ff @(posedge clk or posedge rst) begin
        if (rst)        rd_data <= '0;
        else if (sclr)  rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
      end

      // R9: output holds while no pop is taken
      a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !sclr) |=> $stable(rd_data));
    end else begin : g_ahead
      logic unused_ctl;
      assign unused_ctl = rd_en ^ sclr ^ rst;
      assign rd_data    = mem[rd_addr];
    end
  endgenerate

endmodule

// File: rtl/sc_fifo.sv
module sc_fifo
  import sc_fifo_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ADDR_W       = 4,
  parameter bit          OVF_GUARD    = 1'b1,
  parameter bit          UNF_GUARD    = 1'b1,
  parameter bit          SYNC_RELEASE = 1'b1,
  parameter rd_style_e   RD_STYLE     = RD_REGISTERED
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              sclr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              empty,
  output logic [ADDR_W:0]   level
);

  localparam int unsigned PW        = ADDR_W + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(1) << ADDR_W;

  logic          rst;
  logic          wr_en, rd_en;
  logic [PW-1:0] wr_ptr, rd_ptr;

  sc_fifo_rst #(.SYNC_RELEASE(SYNC_RELEASE)) u_rst (
    .clk(clk), .arst(arst), .rst_o(rst)
  );

  // flags: equal addresses, wrap bit tells full from empty
  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[ADDR_W] != rd_ptr[ADDR_W]) &&
                 (wr_ptr[ADDR_W-1:0] == rd_ptr[ADDR_W-1:0]);
  assign level = wr_ptr - rd_ptr;

  generate
    if (OVF_GUARD) begin : g_ovf
      assign wr_en = push & ~sclr & ~full;
      a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && push && !sclr) |=> (wr_ptr == $past(wr_ptr)));
    end else begin : g_novf
      assign wr_en = push & ~sclr;
    end

    if (UNF_GUARD) begin : g_unf
      assign rd_en = pop & ~sclr & ~empty;
      a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !sclr) |=> (rd_ptr == $past(rd_ptr)));
    end else begin : g_nunf
      assign rd_en = pop & ~sclr;
    end
  endgenerate

  sc_fifo_ptr #(.PW(PW)) u_wptr (
    .clk(clk), .rst(rst), .clr(sclr), .adv(wr_en), .ptr(wr_ptr)
  );

  sc_fifo_ptr #(.PW(PW)) u_rptr (
    .clk(clk), .rst(rst), .clr(sclr), .adv(rd_en), .ptr(rd_ptr)
  );

  sc_fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_STYLE(RD_STYLE)) u_store (
    .clk(clk), .rst(rst), .sclr(sclr),
    .wr_en(wr_en), .wr_addr(wr_ptr[ADDR_W-1:0]), .wr_data(push_data),
    .rd_en(rd_en), .rd_addr(rd_ptr[ADDR_W-1:0]), .rd_data(pop_data)
  );

  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  a_r2_full_level: assert property (@(posedge clk) disable iff (rst)
    full |-> (level == FULL_CNT));

  a_r5_balanced: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !full && !empty && !sclr) |=> (level == $past(level)));

  a_r6_sync_clear: assert property (@(posedge clk) disable iff (rst)
    sclr |=> (empty && !full && level == '0));

  generate
    if (RD_STYLE == RD_LOOKAHEAD) begin : g_ahead_chk
      a_r10_first_word: assert property (@(posedge clk) disable iff (rst)
        (empty && push && !sclr) |=> (!empty && pop_data == $past(push_data)));
    end
  endgenerate

endmodule

// File: tb/sc_fifo_test.sv
module sc_fifo_test;
  import sc_fifo_pkg::*;

  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          arst = 1'b0, sclr = 1'b0, push = 1'b0, pop = 1'b0;
  logic [DW-1:0] push_data = '0;

  logic          n_full, n_empty, l_full, l_empty;
  logic [DW-1:0] n_data, l_data;
  logic [AW:0]   n_level, l_level;

  always #10 clk = ~clk;

  // registered style, synchronized release
  sc_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_RELEASE(1'b1), .RD_STYLE(RD_REGISTERED)) uut (
    .clk(clk), .arst(arst), .sclr(sclr), .push(push), .push_data(push_data),
    .full(n_full), .pop(pop), .pop_data(n_data), .empty(n_empty), .level(n_level));

  // look-ahead style, direct release
  sc_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_RELEASE(1'b0), .RD_STYLE(RD_LOOKAHEAD)) uut_la (
    .clk(clk), .arst(arst), .sclr(sclr), .push(push), .push_data(push_data),
    .full(l_full), .pop(pop), .pop_data(l_data), .empty(l_empty), .level(l_level));

  int            checks = 0, fails = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] last_out = '0;
  bit            done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_level();
    return mq.size();
  endfunction

  task automatic check_all();
    chk("R2 empty registered", int'(n_empty), int'(exp_level() == 0));
    chk("R2 full registered",  int'(n_full),  int'(exp_level() == DEPTH));
    chk("R1 level registered", int'(n_level), exp_level());
    chk("R2 empty lookahead",  int'(l_empty), int'(exp_level() == 0));
    chk("R2 full lookahead",   int'(l_full),  int'(exp_level() == DEPTH));
    chk("R1 level lookahead",  int'(l_level), exp_level());
    chk("R9 registered output", int'(n_data), int'(last_out));
    if (mq.size() > 0) chk("R10 head word", int'(l_data), int'(mq[0]));
  endtask

  // drive one cycle (called just after a falling edge), update model, check after next falling edge
  task automatic step(input bit p, input bit o, input bit s, input logic [DW-1:0] d);
    int  c;
    bit  wa, ra;
    push = p; pop = o; sclr = s; push_data = d;
    if (s) begin
      mq.delete();
      last_out = '0;
    end else begin
      c  = mq.size();
      wa = p && (c < DEPTH);
      ra = o && (c > 0);
      if (ra) last_out = mq.pop_front();
      if (wa) mq.push_back(d);
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'd24681357));
    #2 arst = 1'b1;
    @(negedge clk); @(negedge clk);
    arst = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    // reset state (R7)
    chk("R7 reset empty", int'(n_empty & l_empty), 1);
    chk("R7 reset level", int'(n_level) + int'(l_level), 0);
    check_all();

    // R10: first word into empty buffer
    step(1, 0, 0, 8'hA5);
    chk("R10 first word visible", int'(l_data), 8'hA5);
    chk("R10 empty fell", int'(l_empty), 0);
    // fill to full (R2)
    for (int i = 1; i < DEPTH; i++) step(1, 0, 0, DW'(8'h10 + i));
    chk("R2 full at depth", int'(n_full & l_full), 1);
    // R3: push while full, with and without pop
    step(1, 0, 0, 8'hEE);
    chk("R3 level unchanged", int'(n_level), DEPTH);
    step(1, 1, 0, 8'hEF);
    chk("R3 push dropped with pop", int'(n_level), DEPTH - 1);
    chk("R9 first popped word", int'(n_data), 8'hA5);
    // drain, checking order (R1)
    while (mq.size() > 0) step(0, 1, 0, 8'h00);
    // R4: pop while empty, then pop with push
    step(0, 1, 0, 8'h00);
    chk("R4 pop on empty ignored", int'(n_level), 0);
    step(1, 1, 0, 8'h77);
    chk("R4 pop dropped push kept", int'(n_level), 1);
    chk("R4 registered output kept", int'(n_data), int'(last_out));
    // R5: balanced traffic
    step(1, 0, 0, 8'h78);
    step(1, 0, 0, 8'h79);
    step(1, 1, 0, 8'h7A);
    chk("R5 level held", int'(n_level), 3);
    step(1, 1, 0, 8'h7B);
    chk("R5 level held again", int'(l_level), 3);
    // R6: sync clear beats push and pop
    step(1, 1, 1, 8'h55);
    chk("R6 cleared empty", int'(n_empty & l_empty), 1);
    chk("R6 output zero", int'(n_data), 0);
    // R7: short async pulse between edges
    step(1, 0, 0, 8'h31);
    step(1, 1, 0, 8'h32);
    step(1, 0, 0, 8'h33);
    push = 1'b0; pop = 1'b0;
    #3 arst = 1'b1;
    #3 arst = 1'b0;
    #1;
    chk("R7 pulse empty", int'(n_empty & l_empty), 1);
    chk("R7 pulse full", int'(n_full | l_full), 0);
    chk("R7 pulse level", int'(n_level) + int'(l_level), 0);
    chk("R7 pulse output", int'(n_data), 0);
    mq.delete();
    last_out = '0;
    @(negedge clk);
    step(0, 0, 0, 8'h00);
    step(0, 0, 0, 8'h00);
    step(0, 0, 0, 8'h00);
    // R8: push at the first edge after release
    arst = 1'b1;
    #4 arst = 1'b0;
    push = 1'b1; push_data = 8'h3C;
    @(negedge clk);
    push = 1'b0;
    chk("R8 synchronized release ignores push", int'(n_level), 0);
    chk("R8 direct release takes push", int'(l_level), 1);
    chk("R8 direct release word", int'(l_data), 8'h3C);
    mq.delete();
    last_out = '0;
    step(0, 0, 1, 8'h00);
    step(0, 0, 0, 8'h00);
    step(0, 0, 0, 8'h00);

    // random phases: fill-biased, drain-biased, balanced
    for (int ph = 0; ph < 9; ph++) begin
      int wp, rp;
      case (ph % 3)
        0:       begin wp = 80; rp = 30; end
        1:       begin wp = 25; rp = 75; end
        default: begin wp = 60; rp = 60; end
      endcase
      for (int k = 0; k < 400; k++) begin
        step($urandom_range(99) < wp, $urandom_range(99) < rp,
             $urandom_range(255) == 0, DW'($urandom));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule